// File: doc/BRIEF.md
# Banked Global Register File

This block keeps eight 64-bit global registers that the core reads and writes, plus four backing banks behind them: base, alternate, MMU and interrupt. Which bank the live set belongs to is chosen by three bits of a 12-bit processor-state value. The core loads that value through a dedicated state-write port.

When a state write changes the selection bits, the block runs a swap. It steps through the live registers, one per clock. For each register it stores the live value into the bank being left and then loads the value held by the bank being entered. The new state value becomes visible only when the last register has moved. While the swap runs, `busy` is high and register reads report a stall. Writes to the live registers and further state writes are dropped until `busy` falls.

Top module: `gbank_regfile`

## Requirements
- R1: After reset, all live registers and all bank contents read as zero, the state output is zero (base bank selected) and busy is low.
- R2: A state write keeps only bits 0-5 and 8-11 of the written value (mask 0xf3f); all other bits read back as zero.
- R3: Bank selection comes from state bits 0 (alternate), 10 (MMU) and 11 (interrupt). Exactly one of them set selects that bank. Zero or any combination of two or more selects the base bank.
- R4: A state write accepted while idle whose bits {11,10,0} equal those of the current state causes no swap: busy stays low and the new state is visible one cycle later.
- R5: A state write accepted while idle whose bits {11,10,0} differ from the current state raises busy for exactly 8 cycles. The state output keeps its old value until busy falls and then shows the new value.
- R6: At the end of a swap, the old bank holds the live values from before the swap and the live registers hold the entered bank's stored contents. Bank contents persist across later swaps.
- R7: A swap whose old and new selection decode to the same bank (for example 0x000 to 0xc00) leaves the live register values unchanged.
- R8: The read stall output is high exactly while busy is high. When it is low, the read data shows the live register at the read address.
- R9: Live register writes and state writes presented while busy is high have no effect.
- R10: A live register write while idle updates that register at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr_en | input | 1 | Processor-state write strobe |
| st_wr_data | input | 64 | Value written to the processor state |
| pstate_o | output | 12 | Committed processor state |
| rd_addr | input | 3 | Live register read index |
| rd_data | output | 64 | Live register read value |
| rd_stall | output | 1 | Read not valid, swap in progress |
| wr_en | input | 1 | Live register write strobe |
| wr_addr | input | 3 | Live register write index |
| wr_data | input | 64 | Live register write value |
| busy | output | 1 | Bank swap in progress |

## Verification
The state port is driven with selection codes for each single bank, with the two- and three-bit combinations that fall back to base, and with random junk in the unselected and masked-off bits. The single-bank codes show whether data really moves between distinct banks. The multi-bit codes separate a raw selection change from a real bank change: the swap must run, but live data must stay unchanged. Junk bits tell the keep mask apart from the selection mask. Random live writes between swaps, plus writes and state writes injected in the middle of a swap, show whether each bank keeps its own contents and whether stalled traffic is really dropped.

// File: rtl/gbank_pkg.sv
package gbank_pkg;
  localparam int          STATE_W   = 12;
  localparam int          BANK_W    = 2;
  localparam int          NBANK     = 4;
  localparam logic [11:0] KEEP_MASK = 12'hf3f;
  localparam logic [11:0] SEL_MASK  = 12'hc01;

  typedef enum logic [BANK_W-1:0] {
    BANK_BASE = 2'd0,
    BANK_ALT  = 2'd1,
    BANK_MMU  = 2'd2,
    BANK_INTR = 2'd3
  } bank_e;

  function automatic bank_e sel_to_bank(input logic [STATE_W-1:0] s);
    bank_e b;
    case ({s[11], s[10], s[0]})
      3'b001:  b = BANK_ALT;
      3'b010:  b = BANK_MMU;
      3'b100:  b = BANK_INTR;
      default: b = BANK_BASE;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/gbank_sel_decode.sv
module gbank_sel_decode
  import gbank_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [BANK_W-1:0]  bank_o
);
  always_comb begin
    bank_o = sel_to_bank(state_i);
  end
endmodule

// File: rtl/gbank_swap_ctrl.sv
module gbank_swap_ctrl
  import gbank_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_wr_en,
  input  logic [STATE_W-1:0] st_val,
  output logic [STATE_W-1:0] state_q,
  output logic [STATE_W-1:0] pend_q,
  output logic               busy_q,
  output logic [IDX_W-1:0]   idx_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

  logic [STATE_W-1:0] state_d, pend_d, masked;
  logic               busy_d;
  logic [IDX_W-1:0]   idx_d;
  logic               sel_change;

  always_comb begin
    masked     = st_val & KEEP_MASK;
    sel_change = (masked & SEL_MASK) != (state_q & SEL_MASK);
    state_d    = state_q;
    pend_d     = pend_q;
    busy_d     = busy_q;
    idx_d      = idx_q;
    if (!busy_q) begin
      if (st_wr_en) begin
        if (sel_change) begin
          busy_d = 1'b1;
          idx_d  = '0;
          pend_d = masked;
        end else begin
          state_d = masked;
        end
      end
    end else begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) begin
        busy_d  = 1'b0;
        state_d = pend_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/gbank_storage.sv
module gbank_storage
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              swap_en,
  input  logic [IDX_W-1:0]  swap_idx,
  input  logic [BANK_W-1:0] old_bank,
  input  logic [BANK_W-1:0] new_bank,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] live_q [NREG];
  logic [DATA_W-1:0] live_d [NREG];
  logic              live_en [NREG];
  logic [DATA_W-1:0] bank_q [NBANK][NREG];
  logic              same_bank;

  assign same_bank = (old_bank == new_bank);

  for (genvar r = 0; r < NREG; r++) begin : g_live
    logic at_swap;
    assign at_swap = swap_en && (swap_idx == IDX_W'(r));

    always_comb begin
      live_en[r] = 1'b0;
      live_d[r]  = live_q[r];
      if (at_swap) begin
        live_en[r] = !same_bank;
        live_d[r]  = bank_q[new_bank][r];
      end else if (!swap_en && wr_en && (wr_addr == IDX_W'(r))) begin
        live_en[r] = 1'b1;
        live_d[r]  = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q[r] <= '0;
      else if (live_en[r]) live_q[r] <= live_d[r];
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic save_en;
      assign save_en = at_swap && (old_bank == BANK_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q[b][r] <= '0;
        else if (save_en) bank_q[b][r] <= live_q[r];
      end
    end
  end

  assign rd_data = live_q[rd_addr];
endmodule

// File: rtl/gbank_regfile.sv
module gbank_regfile
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_wr_en,
  input  logic [63:0]        st_wr_data,
  output logic [STATE_W-1:0] pstate_o,
  input  logic [IDX_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_stall,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               busy
);
  logic [STATE_W-1:0] state_q, pend_q;
  logic               busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BANK_W-1:0]  old_bank, new_bank;

  gbank_swap_ctrl #(.NREG(NREG), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_wr_en (st_wr_en),
    .st_val   (st_wr_data[STATE_W-1:0]),
    .state_q  (state_q),
    .pend_q   (pend_q),
    .busy_q   (busy_q),
    .idx_q    (idx_q)
  );

  gbank_sel_decode u_dec_old (.state_i(state_q), .bank_o(old_bank));
  gbank_sel_decode u_dec_new (.state_i(pend_q),  .bank_o(new_bank));

  gbank_storage #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .swap_en  (busy_q),
    .swap_idx (idx_q),
    .old_bank (old_bank),
    .new_bank (new_bank),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  assign pstate_o = state_q;
  assign busy     = busy_q;
  assign rd_stall = busy_q;
endmodule

// File: rtl/gbank_regfile_chk.sv
module gbank_regfile_chk #(
  parameter int NREG = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        st_wr_en,
  input logic [63:0] st_wr_data,
  input logic [11:0] pstate_o,
  input logic        busy
);
  logic [31:0] run_q;
  logic        sel_diff;

  assign sel_diff = (st_wr_data[11:0] & 12'hc01) != (pstate_o & 12'hc01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else run_q <= '0;
  end

  // R2
  state_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o & ~12'hf3f) == 12'h000);

  // R4
  no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && !busy && !sel_diff) |=> (!busy && pstate_o == ($past(st_wr_data[11:0]) & 12'hf3f)));

  // R5
  swap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && !busy && sel_diff) |=> busy);

  // R5
  swap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= NREG);

  // R5
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pstate_o));
endmodule

bind gbank_regfile gbank_regfile_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_wr_en   (st_wr_en),
  .st_wr_data (st_wr_data),
  .pstate_o   (pstate_o),
  .busy       (busy)
);

// File: tb/tb_gbank_regfile.sv
module tb_gbank_regfile;
  logic        clk;
  logic        rst_n;
  logic        st_wr_en;
  logic [63:0] st_wr_data;
  logic [11:0] pstate_o;
  logic [2:0]  rd_addr;
  logic [63:0] rd_data;
  logic        rd_stall;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [63:0] wr_data;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] m_live [8];
  logic [63:0] m_bank [4][8];
  logic [11:0] m_state;

  gbank_regfile dut (
    .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .pstate_o(pstate_o), .rd_addr(rd_addr), .rd_data(rd_data), .rd_stall(rd_stall),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int bank_of(input logic [11:0] s);
    case ({s[11], s[10], s[0]})
      3'b001:  return 1;
      3'b010:  return 2;
      3'b100:  return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i);
      #1;
      check(req, rd_data, m_live[i]);
    end
  endtask

  task automatic live_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_live[a] = d;
    rd_addr = a;
    #1;
    check("R10", rd_data, d);
  endtask

  task automatic st_write(input logic [63:0] v, input string req);
    logic [11:0] nv;
    bit          sw;
    int          ob, nb;
    logic [63:0] tmp;
    nv = v[11:0] & 12'hf3f;
    sw = (nv & 12'hc01) != (m_state & 12'hc01);
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_data = v;
    @(negedge clk);
    st_wr_en = 1'b0;
    if (sw) begin
      for (int k = 0; k < 8; k++) begin
        check("R5 busy", {63'd0, busy}, 64'd1);
        check("R5 state hold", {52'd0, pstate_o}, {52'd0, m_state});
        check("R8 stall", {63'd0, rd_stall}, 64'd1);
        if (k == 3) begin
          wr_en = 1'b1; wr_addr = 3'(k); wr_data = 64'hDEAD_0000_BEEF_0000;
          st_wr_en = 1'b1; st_wr_data = 64'h0000_0000_0000_0801;
        end
        @(negedge clk);
        wr_en = 1'b0; st_wr_en = 1'b0;
      end
      ob = bank_of(m_state);
      nb = bank_of(nv);
      for (int i = 0; i < 8; i++) begin
        tmp = m_live[i];
        m_bank[ob][i] = tmp;
        m_live[i] = (ob == nb) ? tmp : m_bank[nb][i];
      end
    end
    m_state = nv;
    check(sw ? "R5 busy end" : "R4 busy", {63'd0, busy}, 64'd0);
    check(req, {52'd0, pstate_o}, {52'd0, nv});
    check("R8 stall low", {63'd0, rd_stall}, 64'd0);
    read_all(sw ? "R6 R9 content" : "R4 content");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] sels [8];
    void'($urandom(32'd4711));
    sels[0] = 12'h000; sels[1] = 12'h001; sels[2] = 12'h400; sels[3] = 12'h800;
    sels[4] = 12'h401; sels[5] = 12'hc00; sels[6] = 12'hc01; sels[7] = 12'h801;
    rst_n = 1'b0; st_wr_en = 1'b0; st_wr_data = '0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_state = '0;
    for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) m_bank[b][i] = '0;
    for (int i = 0; i < 8; i++) m_live[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 state", {52'd0, pstate_o}, 64'd0);
    read_all("R1 live");

    // directed: fill base, enter each single bank, fill, return
    for (int i = 0; i < 8; i++) live_write(3'(i), 64'h1000 + 64'(i));
    st_write(64'h001, "R3 alt");
    read_all("R1 R6 alt zero");
    for (int i = 0; i < 8; i++) live_write(3'(i), 64'h2000 + 64'(i));
    st_write(64'h400, "R3 mmu");
    for (int i = 0; i < 8; i++) live_write(3'(i), 64'h3000 + 64'(i));
    st_write(64'h800, "R3 intr");
    for (int i = 0; i < 8; i++) live_write(3'(i), 64'h4000 + 64'(i));
    st_write(64'h000, "R3 base");
    st_write(64'h001, "R6 alt back");
    // R7 same bank: 0x401 and 0xc00 both decode to base
    st_write(64'h000, "R7 to base");
    st_write(64'hc00, "R7 base same");
    st_write(64'h401, "R7 base same2");
    // R2 mask: all ones keeps 0xf3f, selection 0xc01 is base
    st_write(64'hFFFF_FFFF_FFFF_FFFF, "R2 mask");
    // R4 no selection change, other bits change
    st_write(64'hABCD_0000_0000_0c3e & 64'hFFFF_FFFF_FFFF_FC3F | 64'h001, "R4 nochange");
    st_write(64'h0000_0000_0000_0c3f, "R4 other bits");

    for (int n = 0; n < 250; n++) begin
      int op;
      op = int'($urandom_range(0, 3));
      if (op == 0) begin
        logic [63:0] v;
        v = {$urandom, $urandom};
        v[11:0] = (v[11:0] & 12'h33e) | sels[$urandom_range(0, 7)];
        st_write(v, "R3 R4 R5 random");
      end else begin
        live_write(3'($urandom_range(0, 7)), {$urandom, $urandom});
      end
    end
    read_all("R6 final");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule